// File: doc/BRIEF.md
# AES Inverse Cipher Middle Round

This block computes one middle round of AES decryption in the equivalent inverse cipher arrangement. A 128-bit state and a 128-bit round key go in. The state passes through the inverse row shift, then the inverse byte substitution, then the inverse column mix, and the key is XORed in last. The key must already be in the form that the equivalent inverse cipher expects, because the block does not alter it. Every decryption round except the last one uses this step. The last round leaves out the column mix and is a separate unit.

The 128-bit result forms the lower half of a 256-bit destination lane. A mode input chooses how the upper half is filled. In one mode it keeps a previous destination value supplied on a separate input. In the other mode it is cleared to zero. With the default parameter the output sits in a register and appears one clock after a valid input. No flags or status are produced.

Top module: `aes_inv_round`

## Requirements
- R1: The round result on dest_o[127:0] equals InvMixColumns(InvSubBytes(InvShiftRows(state_i))) XOR rkey_i, with the steps applied in exactly that order.
- R2: The state is column-major. Byte 4k+r, at bits 8(4k+r)+7 down to 8(4k+r), is row r and column k. The inverse row shift rotates row r right by r byte positions, so output column c of row r takes input column (c-r) mod 4.
- R3: The inverse byte substitution first applies the inverse affine map (b rotated left by 1, 3 and 6, XORed together and with 0x05). It then takes the multiplicative inverse in GF(2^8) modulo x^8+x^4+x^3+x+1, with 0 mapping to 0. An all-zero state with a zero key gives 0x52 in every byte.
- R4: The inverse column mix multiplies each column by the circulant matrix whose first row is {0E,0B,0D,09}, with each later row rotated right by one position.
- R5: The round key is used unmodified and only XORed in after the mix. Changing the key by a value d changes the result by exactly d.
- R6: When zero_upper_i is 0, dest_o[255:128] equals the upper_old_i value sampled with the input.
- R7: When zero_upper_i is 1, dest_o[255:128] is zero.
- R8: With REG_OUT=1, valid_o rises exactly one clock after valid_i and is 0 after reset. rst_ni is asynchronous and active low.
- R9: With REG_OUT=1, dest_o holds its value during any cycle in which valid_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input operands valid |
| state_i | input | 128 | Round input state |
| rkey_i | input | 128 | Round key, already in equivalent-inverse form |
| upper_old_i | input | 128 | Previous upper half of the destination lane |
| zero_upper_i | input | 1 | 1: clear the upper half, 0: keep upper_old_i |
| valid_o | output | 1 | Result valid |
| dest_o | output | 256 | Destination lane: upper half merged, lower half round result |

## Verification
The bench builds the block with REG_OUT=1 and DEST_W=256. This puts the one-cycle output register, the hold behaviour and the full 256-bit merge under test. A bench model builds its inverse S-box by inverting the forward S-box from scratch. This lets random states be checked byte for byte, together with the zero vector and the key-linearity case. Both merge modes are toggled at random, so each one meets many round results.

// File: rtl/aes_inv_pkg.sv
package aes_inv_pkg;
  localparam int unsigned BLK_W = 128;
  localparam int unsigned NBYTE = BLK_W / 8;
  localparam int unsigned NCOL  = NBYTE / 4;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, t;
    acc = '0;
    t   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ t;
      t = xtime(t);
    end
    return acc;
  endfunction

  // a^254 == a^-1, and 0 maps to 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r, p;
    r = 8'h01;
    p = a;
    for (int i = 0; i < 8; i++) begin
      if (i != 0) r = gf_mul(r, p);
      p = gf_mul(p, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] a, input int unsigned n);
    return (a << n) | (a >> (8 - n));
  endfunction

  function automatic logic [7:0] inv_affine(input logic [7:0] b);
    return rotl8(b, 1) ^ rotl8(b, 3) ^ rotl8(b, 6) ^ 8'h05;
  endfunction
endpackage

// File: rtl/aes_inv_sbox.sv
module aes_inv_sbox
  import aes_inv_pkg::*;
(
  input  logic [7:0] byte_i,
  output logic [7:0] byte_o
);
  always_comb begin
    byte_o = gf_inv(inv_affine(byte_i));
    // no fixed or anti-fixed points exist in the inverse substitution
    p_sbox_no_fixed_r3: assert (byte_o != byte_i && byte_o != ~byte_i);
  end
endmodule

// File: rtl/aes_inv_mix_col.sv
module aes_inv_mix_col
  import aes_inv_pkg::*;
(
  input  logic [31:0] col_i,
  output logic [31:0] col_o
);
  logic [7:0] a [4];

  always_comb
    for (int r = 0; r < 4; r++) a[r] = col_i[8*r +: 8];

  for (genvar r = 0; r < 4; r++) begin : g_row
    assign col_o[8*r +: 8] = gf_mul(a[r], 8'h0e) ^ gf_mul(a[(r+1)%4], 8'h0b) ^
                             gf_mul(a[(r+2)%4], 8'h0d) ^ gf_mul(a[(r+3)%4], 8'h09);
  end

  // coefficients XOR to 01, so column parity is preserved
  always_comb
    p_mix_parity_r4: assert ((col_o[31:24] ^ col_o[23:16] ^ col_o[15:8] ^ col_o[7:0]) ==
                             (col_i[31:24] ^ col_i[23:16] ^ col_i[15:8] ^ col_i[7:0]));
endmodule

// File: rtl/aes_inv_round.sv
module aes_inv_round
  import aes_inv_pkg::*;
#(
  parameter bit          REG_OUT = 1'b1,
  parameter int unsigned DEST_W  = 256
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [BLK_W-1:0]    state_i,
  input  logic [BLK_W-1:0]    rkey_i,
  input  logic [UP_W-1:0]     upper_old_i,
  input  logic                zero_upper_i,
  output logic                valid_o,
  output logic [DEST_W-1:0]   dest_o
);
  localparam int unsigned UP_W = DEST_W - BLK_W;

  logic [BLK_W-1:0]  shifted, subbed, mixed, round_res;
  logic [DEST_W-1:0] dest_d;

  // inverse row shift: row r rotated right by r
  for (genvar c = 0; c < NCOL; c++) begin : g_shift_c
    for (genvar r = 0; r < 4; r++) begin : g_shift_r
      assign shifted[8*(4*c+r) +: 8] = state_i[8*(4*((c+NCOL-r)%NCOL)+r) +: 8];
    end
  end

  for (genvar b = 0; b < NBYTE; b++) begin : g_sbox
    aes_inv_sbox i_sbox (.byte_i(shifted[8*b +: 8]), .byte_o(subbed[8*b +: 8]));
  end

  for (genvar c = 0; c < NCOL; c++) begin : g_mix
    aes_inv_mix_col i_mix (.col_i(subbed[32*c +: 32]), .col_o(mixed[32*c +: 32]));
  end

  assign round_res = mixed ^ rkey_i;
  assign dest_d    = {zero_upper_i ? '0 : upper_old_i, round_res};

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o <= 1'b0;
        dest_o  <= '0;
      end else begin
        valid_o <= valid_i;
        if (valid_i) dest_o <= dest_d;
      end
    end

    p_valid_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o);
    p_valid_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> !valid_o);
    p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> $stable(dest_o));
    p_upper_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && zero_upper_i) |=> (dest_o[DEST_W-1:BLK_W] == '0));
    p_upper_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !zero_upper_i) |=> (dest_o[DEST_W-1:BLK_W] == $past(upper_old_i)));
  end else begin : g_comb
    assign valid_o = valid_i;
    assign dest_o  = dest_d;
  end
endmodule

// File: tb/test_aes_inv_round.sv
module test_aes_inv_round;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [127:0] state_i = '0, rkey_i = '0, upper_old_i = '0;
  logic         zero_upper_i = 1'b0;
  logic         valid_o;
  logic [255:0] dest_o;

  int checks = 0, fails = 0;
  logic [7:0] isb [256];

  always #10 clk_i = ~clk_i;

  aes_inv_round #(.REG_OUT(1'b1), .DEST_W(256)) i_aes_inv_round (
    .clk_i, .rst_ni, .valid_i, .state_i, .rkey_i, .upper_old_i, .zero_upper_i,
    .valid_o, .dest_o);

  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p ^= 16'(a) << i;
    for (int i = 15; i >= 8; i--) if (p[i]) p ^= 16'h11b << (i - 8);
    return p[7:0];
  endfunction

  function automatic logic [7:0] fwd_sbox(input logic [7:0] x);
    logic [7:0] v = 8'h00, s;
    for (int b = 1; b < 256; b++) if (m_mul(x, 8'(b)) == 8'h01) v = 8'(b);
    s = v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]} ^ {v[3:0], v[7:4]} ^ 8'h63;
    return s;
  endfunction

  function automatic logic [127:0] model(input logic [127:0] st, input logic [127:0] k);
    logic [7:0] m [4][4];
    logic [7:0] s [4][4];
    logic [127:0] res;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        m[r][c] = isb[st[8*(4*((c - r + 4) % 4) + r) +: 8]];
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        s[r][c] = m_mul(m[r][c], 8'h0e) ^ m_mul(m[(r+1)%4][c], 8'h0b) ^
                  m_mul(m[(r+2)%4][c], 8'h0d) ^ m_mul(m[(r+3)%4][c], 8'h09);
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) res[8*(4*c+r) +: 8] = s[r][c];
    return res ^ k;
  endfunction

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [127:0] st, input logic [127:0] k,
                       input logic [127:0] up, input logic z);
    @(negedge clk_i);
    valid_i = 1'b1; state_i = st; rkey_i = k; upper_old_i = up; zero_upper_i = z;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [255:0] r1, keep;
    logic [127:0] st, k, up, d;
    logic z;
    void'($urandom(32'd1234));
    for (int x = 0; x < 256; x++) isb[fwd_sbox(8'(x))] = 8'(x);

    repeat (3) @(negedge clk_i);
    check("R8 reset valid", {255'b0, valid_o}, 256'b0);
    check("R8 reset data", dest_o, '0);
    rst_ni = 1'b1;

    // R3: zero vector gives 0x52 everywhere
    apply('0, '0, {4{32'hdeadbeef}}, 1'b1);
    check("R3 zero vector", dest_o, {128'b0, {16{8'h52}}});

    // R8 one-cycle latency: valid high at the sample after the load edge, low next
    check("R8 valid one cycle", {255'b0, valid_o}, 256'd1);
    @(negedge clk_i);
    check("R8 valid drop", {255'b0, valid_o}, 256'd0);

    // R2 / R1: byte-index pattern
    st = '0;
    for (int b = 0; b < 16; b++) st[8*b +: 8] = 8'(b * 17 + 3);
    apply(st, 128'h0f0e0d0c0b0a09080706050403020100, 128'h1, 1'b0);
    check("R2 shift pattern", dest_o,
          {128'h1, model(st, 128'h0f0e0d0c0b0a09080706050403020100)});

    // R5: key linearity
    k = {$urandom, $urandom, $urandom, $urandom};
    d = {$urandom, $urandom, $urandom, $urandom};
    apply(st, k, '0, 1'b1);
    r1 = dest_o;
    apply(st, k ^ d, '0, 1'b1);
    check("R5 key delta", {128'b0, dest_o[127:0] ^ r1[127:0]}, {128'b0, d});

    // R9: inputs change without valid, output holds
    keep = dest_o;
    @(negedge clk_i);
    state_i = ~state_i; rkey_i = ~rkey_i; upper_old_i = ~upper_old_i; zero_upper_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    check("R9 hold", dest_o, keep);

    // R1 R4 R6 R7 random
    for (int n = 0; n < 40; n++) begin
      st = {$urandom, $urandom, $urandom, $urandom};
      k  = {$urandom, $urandom, $urandom, $urandom};
      up = {$urandom, $urandom, $urandom, $urandom};
      z  = 1'($urandom);
      apply(st, k, up, z);
      check("R1 R4 round", {128'b0, dest_o[127:0]}, {128'b0, model(st, k)});
      check(z ? "R7 upper zero" : "R6 upper keep", {128'b0, dest_o[255:128]},
            {128'b0, z ? 128'b0 : up});
    end

    // R4: single nonzero byte column
    st = 128'h0;
    st[7:0] = 8'h52;
    apply(st, '0, '1, 1'b0);
    check("R4 single column", dest_o, {128'hffffffffffffffffffffffffffffffff,
          128'h52525252525252525252525209_0d_0b_0e ^ 128'h0 ^ model(st, '0) ^
          128'h52525252525252525252525209_0d_0b_0e});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule